// File: doc/BRIEF.md
# SIMD Integer Arithmetic Lane Unit

This block is a 128-bit packed-integer arithmetic stage. It takes two source vectors and an element-size code. The code splits each vector into sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. The unit then applies one operation to every lane pair at the same time. The operation is add, subtract, minimum, maximum or rounding average. Each lane's result lands in the same bit field of the output vector.

A signedness flag selects how lane values are read, as two's complement or as unsigned. For add and subtract, a mode flag chooses between two behaviours. In wraparound mode the result keeps the low bits. In clamping mode the result is held to the lane's representable range. The result is captured in an output register together with a valid strobe. A sticky status bit records that a clamp happened in some lane. This bit stays set until software-visible logic pulses the clear input.

Top module: `simd_lane_unit`

## Requirements
- R1: Element-size code `esize` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 or 3 gives 32-bit lanes. Lane i occupies bits [i*W +: W] of each source and of the result, and no carry or borrow passes between lanes.
- R2: Operation code `op` selects the operation: 0 = add, 1 = subtract (a - b), 2 = minimum, 3 = maximum, 4 = rounding average. Codes 5 to 7 give an all-zero result and never count as a clamp.
- R3: With `saturate` low, add and subtract keep the low W bits of the exact result (wraparound).
- R4: With `saturate` high, an add or subtract result above the lane maximum gives the maximum. A result below the lane minimum gives the minimum. The range is [-2^(W-1), 2^(W-1)-1] when `is_signed` is high and [0, 2^W-1] when it is low, so an unsigned subtract that would go negative gives 0.
- R5: Minimum and maximum compare lanes as two's complement when `is_signed` is high and as unsigned otherwise. `saturate` has no effect on them.
- R6: Rounding average returns (a + b + 1) >> 1, computed with enough extra precision that the sum never overflows. The shift is arithmetic for signed lanes. `saturate` has no effect on it.
- R7: When `in_valid` is high at a rising clock edge, `result` and `out_valid` update at that edge. The result is visible one cycle after the inputs. When `in_valid` is low, `out_valid` drops and `result` holds its previous value.
- R8: `sat_flag` becomes 1 at the edge where an accepted operation clamps any lane. It stays 1 until an edge with `sat_clr` high. If a new clamp and `sat_clr` coincide, the flag is set.
- R9: After asynchronous active-low reset, `result`, `out_valid` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| esize | input | 2 | Element size code |
| is_signed | input | 1 | Lanes are two's complement when high |
| saturate | input | 1 | Clamp add/subtract results when high |
| op | input | 3 | Operation code |
| sat_clr | input | 1 | Clears the sticky clamp flag |
| result | output | 128 | Registered lane-wise result |
| out_valid | output | 1 | Result register was loaded at the last edge |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
Carry isolation is the hardest case to reach from the ports. Random operands seldom carry out of exactly the bit where a lane ends. The stimulus therefore fills every byte with 0xFF or 0x7F and adds one in wraparound and clamping modes at each element size. A carry leaking into the next lane then shows up as a changed neighbour field. The same one-away-from-limit patterns cover the clamp boundaries. A clear pulse timed on the same cycle as a clamping operation covers the set-wins rule of the sticky flag.

// File: rtl/simd_pkg.sv
package simd_pkg;
   typedef logic [2:0] opcode_t;
   typedef logic [1:0] esize_t;

   localparam opcode_t OPC_ADD = 3'd0;
   localparam opcode_t OPC_SUB = 3'd1;
   localparam opcode_t OPC_MIN = 3'd2;
   localparam opcode_t OPC_MAX = 3'd3;
   localparam opcode_t OPC_AVG = 3'd4;

   localparam esize_t ES_BYTE = 2'd0;
   localparam esize_t ES_HALF = 2'd1;

   localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0]        a,
   input  logic [W-1:0]        b,
   input  logic                is_signed,
   input  logic                saturate,
   input  simd_pkg::opcode_t   op,
   output logic [W-1:0]        y,
   output logic                clamped
);
   import simd_pkg::*;

   localparam int EW = W + 2;
   localparam logic signed [EW-1:0] ONE = EW'(1);

   logic signed [EW-1:0] ea, eb, sum, dif, pick, lim_hi, lim_lo, rnd;
   logic                 arith;

   if (W < 2) begin : g_bad_w
      $error("simd_lane_alu: lane width must be at least 2");
   end

   always_comb begin
      ea     = {{2{a[W-1] & is_signed}}, a};
      eb     = {{2{b[W-1] & is_signed}}, b};
      sum    = ea + eb;
      dif    = ea - eb;
      rnd    = sum + ONE;
      lim_hi = is_signed ? {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
      lim_lo = is_signed ? {3'b111, {(W-1){1'b0}}} : '0;
      arith  = (op == OPC_ADD) || (op == OPC_SUB);
      clamped = 1'b0;
      unique case (op)
         OPC_ADD: pick = sum;
         OPC_SUB: pick = dif;
         OPC_MIN: pick = (ea < eb) ? ea : eb;
         OPC_MAX: pick = (ea < eb) ? eb : ea;
         OPC_AVG: pick = rnd >>> 1;
         default: pick = '0;
      endcase
      if (arith && saturate) begin
         if (pick > lim_hi) begin
            pick    = lim_hi;
            clamped = 1'b1;
         end else if (pick < lim_lo) begin
            pick    = lim_lo;
            clamped = 1'b1;
         end
      end
      y = pick[W-1:0];
   end

   // Clamping only ever comes from saturating add/subtract (R4, R5, R6)
   always_comb begin
      p_clamp_only_arith_r4: assert (!clamped || (saturate && arith))
         else $error("clamp reported outside saturating add/sub");
   end
endmodule

// File: rtl/simd_size_slice.sv
module simd_size_slice #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8
) (
   input  logic [VEC_W-1:0]    a,
   input  logic [VEC_W-1:0]    b,
   input  logic                is_signed,
   input  logic                saturate,
   input  simd_pkg::opcode_t   op,
   output logic [VEC_W-1:0]    y,
   output logic                any_clamp
);
   localparam int LANES = VEC_W / LANE_W;

   logic [LANES-1:0] lane_clamp;

   if (VEC_W % LANE_W != 0) begin : g_bad_split
      $error("simd_size_slice: vector width not a multiple of lane width");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      simd_lane_alu #(.W(LANE_W)) u_alu (
         .a         (a[i*LANE_W +: LANE_W]),
         .b         (b[i*LANE_W +: LANE_W]),
         .is_signed (is_signed),
         .saturate  (saturate),
         .op        (op),
         .y         (y[i*LANE_W +: LANE_W]),
         .clamped   (lane_clamp[i])
      );
   end

   assign any_clamp = |lane_clamp;
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
   parameter int VEC_W   = 128,
   parameter int LANE0_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [1:0]       esize,
   input  logic             is_signed,
   input  logic             saturate,
   input  logic [2:0]       op,
   input  logic             sat_clr,
   output logic [VEC_W-1:0] result,
   output logic             out_valid,
   output logic             sat_flag
);
   import simd_pkg::*;

   localparam int WIDEST = LANE0_W << (NUM_SIZES - 1);

   if (VEC_W % WIDEST != 0) begin : g_bad_vec
      $error("simd_lane_unit: VEC_W must be a multiple of the widest lane");
   end

   logic [VEC_W-1:0] slice_y   [NUM_SIZES];
   logic             slice_sat [NUM_SIZES];
   logic [VEC_W-1:0] nxt_y;
   logic             nxt_sat;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      simd_size_slice #(.VEC_W(VEC_W), .LANE_W(LANE0_W << g)) u_slice (
         .a         (src_a),
         .b         (src_b),
         .is_signed (is_signed),
         .saturate  (saturate),
         .op        (op),
         .y         (slice_y[g]),
         .any_clamp (slice_sat[g])
      );
   end

   always_comb begin
      unique case (esize)
         ES_BYTE: begin nxt_y = slice_y[0]; nxt_sat = slice_sat[0]; end
         ES_HALF: begin nxt_y = slice_y[1]; nxt_sat = slice_sat[1]; end
         default: begin nxt_y = slice_y[2]; nxt_sat = slice_sat[2]; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         out_valid <= 1'b0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt_y;
         sat_flag  <= (sat_flag & ~sat_clr) | (in_valid & nxt_sat);
      end
   end

   p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_result_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && nxt_sat) |=> sat_flag);
   p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag);
   p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !(in_valid && nxt_sat)) |=> !sat_flag);
endmodule

// File: tb/simd_lane_unit_tb.sv
module simd_lane_unit_tb;
   typedef struct {
      logic [127:0] res;
      logic         stk;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0, src_b = '0;
   logic [1:0]   esize = '0;
   logic         is_signed = 1'b0, saturate = 1'b0, sat_clr = 1'b0;
   logic [2:0]   op = '0;
   logic [127:0] result;
   logic         out_valid, sat_flag;

   int   n_chk = 0, n_fail = 0;
   exp_t q[$];
   logic exp_stk = 1'b0;
   logic [127:0] last_res = '0;

   always #10 clk = ~clk;

   simd_lane_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .esize(esize), .is_signed(is_signed), .saturate(saturate), .op(op),
      .sat_clr(sat_clr), .result(result), .out_valid(out_valid), .sat_flag(sat_flag)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
         input logic [1:0] es, input logic sg, input logic st, input logic [2:0] o,
         output logic hit);
      int w = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : 32;
      longint mask = (64'sd1 <<< w) - 1;
      logic [127:0] acc = '0;
      hit = 1'b0;
      for (int i = 0; i < 128 / w; i++) begin
         logic [127:0] ta, tb;
         longint x, y, r, mx, mn;
         ta = a >> (i * w);
         tb = b >> (i * w);
         x = longint'(ta[31:0]) & mask;
         y = longint'(tb[31:0]) & mask;
         if (sg && ((x >>> (w - 1)) & 1) == 1) x = x - (64'sd1 <<< w);
         if (sg && ((y >>> (w - 1)) & 1) == 1) y = y - (64'sd1 <<< w);
         case (o)
            3'd0: r = x + y;
            3'd1: r = x - y;
            3'd2: r = (x < y) ? x : y;
            3'd3: r = (x < y) ? y : x;
            3'd4: r = (x + y + 1) >>> 1;
            default: r = 0;
         endcase
         if (st && o <= 3'd1) begin
            mx = sg ? (64'sd1 <<< (w - 1)) - 1 : mask;
            mn = sg ? -(64'sd1 <<< (w - 1)) : 0;
            if (r > mx) begin r = mx; hit = 1'b1; end
            else if (r < mn) begin r = mn; hit = 1'b1; end
         end
         acc = acc | ((128'(r & mask)) << (i * w));
      end
      return acc;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: called at a falling edge, leaves at the next falling edge
   task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
         input logic sg, input logic st, input logic [2:0] o, input logic clr, input string tag);
      exp_t e;
      logic hit;
      e.res = model(a, b, es, sg, st, o, hit);
      exp_stk = (exp_stk & ~clr) | hit;
      e.stk = exp_stk;
      e.tag = tag;
      last_res = e.res;
      q.push_back(e);
      src_a = a; src_b = b; esize = es; is_signed = sg; saturate = st; op = o;
      sat_clr = clr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; sat_clr = 1'b0;
   endtask

   task automatic idle(input logic clr, input string tag);
      src_a = {4{$urandom}}; src_b = {4{$urandom}};
      in_valid = 1'b0; sat_clr = clr;
      exp_stk = exp_stk & ~clr;
      @(negedge clk);
      sat_clr = 1'b0;
      check({tag, " out_valid low"}, 128'(out_valid), 128'(0));
      check({tag, " result held"}, result, last_res);
      check({tag, " sticky"}, 128'(sat_flag), 128'(exp_stk));
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7: actual out_valid 1 expected no pending result");
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " result"}, result, e.res);
            check({"R8 sticky after ", e.tag}, 128'(sat_flag), 128'(e.stk));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset result", result, '0);
      check("R9 reset out_valid", 128'(out_valid), 128'(0));
      check("R9 reset sat_flag", 128'(sat_flag), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R3: carry isolation in wraparound mode at each size
      drive({16{8'hFF}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R1 R3 byte wrap");
      drive({8{16'h00FF}}, {8{16'h0001}}, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R1 byte no carry");
      drive({8{16'h00FF}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, "R1 half inner carry");
      drive({4{32'hFFFF_FFFF}}, {4{32'h1}}, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0, "R1 R3 word wrap");
      drive({4{32'h0000_FFFF}}, {4{32'h1}}, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0, "R1 esize3 word");
      drive({16{8'h00}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0, "R3 byte borrow");
      idle(1'b0, "R7 hold no clamp");
      // R4 clamps
      drive({16{8'hFF}}, {16{8'h01}}, 2'd0, 1'b0, 1'b1, 3'd0, 1'b0, "R4 unsigned add clamp");
      idle(1'b0, "R8 sticky hold");
      idle(1'b1, "R8 clear");
      drive({16{8'h7F}}, {16{8'h01}}, 2'd0, 1'b1, 1'b1, 3'd0, 1'b0, "R4 signed add clamp");
      drive({8{16'h8000}}, {8{16'h0001}}, 2'd1, 1'b1, 1'b1, 3'd1, 1'b1, "R4 R8 signed sub clamp set wins");
      drive({4{32'h1}}, {4{32'h2}}, 2'd2, 1'b0, 1'b1, 3'd1, 1'b1, "R4 unsigned sub floor");
      idle(1'b1, "R8 clear again");
      drive({8{16'h7FFE}}, {8{16'h0001}}, 2'd1, 1'b1, 1'b1, 3'd0, 1'b0, "R4 no clamp at limit");
      // R5 / R6 / R2
      drive({16{8'h80}}, {16{8'h01}}, 2'd0, 1'b1, 1'b1, 3'd2, 1'b0, "R5 signed min");
      drive({16{8'h80}}, {16{8'h01}}, 2'd0, 1'b0, 1'b1, 3'd2, 1'b0, "R5 unsigned min");
      drive({8{16'h8000}}, {8{16'h0001}}, 2'd1, 1'b1, 1'b0, 3'd3, 1'b0, "R5 signed max");
      drive({16{8'hFF}}, {16{8'hFF}}, 2'd0, 1'b0, 1'b1, 3'd4, 1'b0, "R6 unsigned avg top");
      drive({16{8'hFF}}, {16{8'hFE}}, 2'd0, 1'b1, 1'b0, 3'd4, 1'b0, "R6 signed avg neg");
      drive({4{32'h8000_0000}}, {4{32'h8000_0001}}, 2'd2, 1'b1, 1'b1, 3'd4, 1'b0, "R6 word avg");
      drive({16{8'h7F}}, {16{8'h7F}}, 2'd0, 1'b1, 1'b1, 3'd5, 1'b0, "R2 reserved op");
      drive({16{8'h7F}}, {16{8'h7F}}, 2'd1, 1'b0, 1'b1, 3'd7, 1'b0, "R2 reserved op 7");
      idle(1'b0, "R7 hold after burst");

      for (int k = 0; k < 400; k++) begin
         logic [127:0] ra, rb;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         if (k % 3 == 0) rb = ra ^ {4{32'h8080_8080}};
         drive(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 6),
               ($urandom % 8) == 0, "R1 R2 R3 R4 R5 R6 random");
         if (k % 37 == 0) idle(1'($urandom), "R7 R8 random idle");
      end
      @(negedge clk);
      @(negedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R7: actual %0d pending expected 0", q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule